// File: doc/BRIEF.md
# Configurable Serial Character Receiver

This block turns a serial receive line into 8-bit characters. Each character is checked for parity and framing, and all-zero line conditions are reported as break. There are two timing modes. In asynchronous mode, a `tick` enable runs at 8, 16 or 32 times the bit rate. The start bit is confirmed at its middle, and each later bit is sampled at the centre of its period. In isochronous mode, every `tick` carries exactly one bit.

A zero-stop-bit option lets characters follow each other with no stop bit between them. It is honoured only in isochronous mode. A gating option makes the receiver deaf while the local transmitter reports that it is busy, so a node on a shared line does not read its own traffic. Each completed character is presented for one cycle together with its flags. The data and flags then hold until the next character.

Top module: `uart_rx_core`

## Requirements
- R1: After reset, `rx_valid`, `rx_perr`, `rx_ferr` and `rx_brk` are 0 and `rx_data` is 8'h00.
- R2: With `cfg_sync`=0, the `cfg_os` setting picks the number of ticks per bit: 2'b00 gives 8, 2'b01 gives 16, 2'b10 gives 32 and 2'b11 gives 16. A low line is accepted as a start bit only if it is still low half a bit later. Data bits arrive least significant bit first.
- R3: With `cfg_sync`=1, each tick samples one bit. A 0 seen while idle is the start bit, and the next 8 ticks carry data, least significant bit first.
- R4: With `cfg_par_en`=1, one parity bit follows the data. `cfg_par_mode` selects how it is checked: 2'b00 odd (data plus parity holds an odd count of ones), 2'b01 space (bit must be 0), 2'b10 even, 2'b11 mark (bit must be 1). A mismatch sets `rx_perr`.
- R5: With `cfg_par_en`=0, no parity bit is expected and `rx_perr` stays 0. A change of `cfg_par_mode` between characters applies to the next character without a reset.
- R6: In normal stop mode, a 0 sampled in the stop position sets `rx_ferr`. A 1 clears it.
- R7: In normal stop mode, a character whose data bits and parity bit (if enabled) are all 0 and whose stop bit is 0 sets `rx_brk`, along with `rx_ferr`.
- R8: In zero-stop mode (`cfg_zstop`=1 and `cfg_sync`=1), a 0 in the stop position sets `rx_ferr` and also acts as the start bit of the next character. The following tick is that character's data bit 0.
- R9: In zero-stop mode, `rx_brk` is set only on the second of two back-to-back all-zero characters that both lack a stop bit. The first of them reports only `rx_ferr`.
- R10: With `cfg_sync`=0, `cfg_zstop` has no effect, and the normal stop rules of R6 and R7 apply.
- R11: While `cfg_rx_gate`=1 and `tx_busy`=1, the line is ignored, no character is delivered, and any partial character is dropped. With `cfg_rx_gate`=0, `tx_busy` has no effect.
- R12: `rx_valid` is a one-cycle pulse in the clock cycle after the edge that samples the stop bit. `rx_data` and the flags hold their values until the next pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_in | input | 1 | Serial receive line, idle high |
| tick | input | 1 | Oversample enable (async) or bit strobe (sync) |
| cfg_sync | input | 1 | 1: one bit per tick; 0: oversampled |
| cfg_os | input | 2 | Oversample ratio select |
| cfg_zstop | input | 1 | Allow characters without stop bits |
| cfg_par_en | input | 1 | Parity bit present and checked |
| cfg_par_mode | input | 2 | Parity check kind |
| cfg_rx_gate | input | 1 | Mute receiver while transmitter busy |
| tx_busy | input | 1 | Local transmitter is sending |
| rx_valid | output | 1 | Character complete pulse |
| rx_data | output | 8 | Received character |
| rx_perr | output | 1 | Parity error |
| rx_ferr | output | 1 | Framing error (stop bit was 0) |
| rx_brk | output | 1 | Break detected |

## Verification
In zero-stop mode, a single sampling edge both finishes one character and starts the next. That edge reports the framing error, and possibly break, and also re-enters data reception. The bench provokes this with chained characters that share the stop and start slot: a non-zero character followed directly by a clean one, then two all-zero characters with no stop bits, then a clean character. It judges the result by the exact number of delivered characters and by the data and flags of each. A lost or duplicated character, or a break raised one character early, shows up directly in that record.

// File: rtl/uart_rx_core.sv
module uart_rx_core (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rx_in,
  input  logic       tick,
  input  logic       cfg_sync,
  input  logic [1:0] cfg_os,
  input  logic       cfg_zstop,
  input  logic       cfg_par_en,
  input  logic [1:0] cfg_par_mode,
  input  logic       cfg_rx_gate,
  input  logic       tx_busy,
  output logic       rx_valid,
  output logic [7:0] rx_data,
  output logic       rx_perr,
  output logic       rx_ferr,
  output logic       rx_brk
);
  typedef enum logic [2:0] {S_IDLE, S_START, S_DATA, S_PAR, S_STOP} st_t;

  st_t        st;
  logic [4:0] cnt;
  logic [2:0] bitn;
  logic [7:0] sh;
  logic       pbit;
  logic       prev_zero;
  logic [5:0] os_n;
  logic       perr_c;

  wire gated = cfg_rx_gate & tx_busy;
  wire zs    = cfg_zstop & cfg_sync;

  always_comb begin
    case (cfg_os)
      2'b00:   os_n = 6'd8;
      2'b10:   os_n = 6'd32;
      default: os_n = 6'd16;
    endcase
  end

  wire [5:0] lim     = (st == S_START) ? (os_n >> 1) - 6'd1 : os_n - 6'd1;
  wire       samp    = tick && (cfg_sync || cnt == lim[4:0]);
  wire       allzero = (sh == 8'h00) && !(cfg_par_en && pbit);

  always_comb begin
    case (cfg_par_mode)
      2'b00:   perr_c = ~(^sh ^ pbit);
      2'b01:   perr_c = pbit;
      2'b10:   perr_c = ^sh ^ pbit;
      default: perr_c = ~pbit;
    endcase
    perr_c = perr_c & cfg_par_en;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE; cnt <= '0; bitn <= '0; sh <= '0; pbit <= 1'b0;
      prev_zero <= 1'b0; rx_valid <= 1'b0; rx_data <= '0;
      rx_perr <= 1'b0; rx_ferr <= 1'b0; rx_brk <= 1'b0;
    end else begin
      rx_valid <= 1'b0;
      if (gated) begin
        st <= S_IDLE; cnt <= '0; prev_zero <= 1'b0;
      end else if (tick) begin
        cnt <= samp ? 5'd0 : cnt + 5'd1;
        case (st)
          S_IDLE: begin
            cnt  <= '0;
            bitn <= '0;
            if (!rx_in) st <= cfg_sync ? S_DATA : S_START;
          end
          S_START: if (samp) st <= rx_in ? S_IDLE : S_DATA;
          S_DATA: if (samp) begin
            sh   <= {rx_in, sh[7:1]};
            bitn <= bitn + 3'd1;
            if (bitn == 3'd7) st <= cfg_par_en ? S_PAR : S_STOP;
          end
          S_PAR: if (samp) begin
            pbit <= rx_in;
            st   <= S_STOP;
          end
          S_STOP: if (samp) begin
            rx_valid  <= 1'b1;
            rx_data   <= sh;
            rx_perr   <= perr_c;
            rx_ferr   <= !rx_in;
            rx_brk    <= !rx_in && allzero && (!zs || prev_zero);
            prev_zero <= zs && !rx_in && allzero;
            bitn      <= '0;
            st        <= (zs && !rx_in) ? S_DATA : S_IDLE;
          end
          default: st <= S_IDLE;
        endcase
      end
    end
  end

  p_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);
  p_gate_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    gated |=> !rx_valid);
  p_brk_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && rx_brk) |-> (rx_ferr && rx_data == 8'h00));
  p_perr_needs_par_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && rx_perr) |-> $past(cfg_par_en));
  p_resync_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && rx_ferr && $past(zs && !gated)) |-> (st == S_DATA));
endmodule

// File: tb/uart_rx_core_test.sv
module uart_rx_core_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rx_in = 1'b1;
  logic       tick = 1'b1;
  logic       cfg_sync = 1'b0;
  logic [1:0] cfg_os = 2'b01;
  logic       cfg_zstop = 1'b0;
  logic       cfg_par_en = 1'b0;
  logic [1:0] cfg_par_mode = 2'b00;
  logic       cfg_rx_gate = 1'b0;
  logic       tx_busy = 1'b0;
  logic       rx_valid;
  logic [7:0] rx_data;
  logic       rx_perr, rx_ferr, rx_brk;

  int n_run = 0, n_fail = 0, ncap = 0;
  logic [10:0] cap [64];
  bit done = 0;

  always #2.5 clk = ~clk;

  uart_rx_core uut (
    .clk(clk), .rst_n(rst_n), .rx_in(rx_in), .tick(tick), .cfg_sync(cfg_sync),
    .cfg_os(cfg_os), .cfg_zstop(cfg_zstop), .cfg_par_en(cfg_par_en),
    .cfg_par_mode(cfg_par_mode), .cfg_rx_gate(cfg_rx_gate), .tx_busy(tx_busy),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_perr(rx_perr),
    .rx_ferr(rx_ferr), .rx_brk(rx_brk));

  always @(negedge clk) if (rst_n && rx_valid) begin
    if (ncap < 64) cap[ncap] = {rx_data, rx_perr, rx_ferr, rx_brk};
    ncap++;
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic par_of(logic [7:0] d, logic [1:0] m);
    case (m)
      2'b00: par_of = ~^d;
      2'b01: par_of = 1'b0;
      2'b10: par_of = ^d;
      default: par_of = 1'b1;
    endcase
  endfunction

  task automatic send_bit(logic b, int n);
    @(negedge clk) rx_in = b;
    repeat (n - 1) @(negedge clk);
  endtask

  task automatic send_frame(logic [7:0] d, logic hp, logic p, logic s, int n);
    send_bit(1'b0, n);
    for (int i = 0; i < 8; i++) send_bit(d[i], n);
    if (hp) send_bit(p, n);
    send_bit(s, n);
    send_bit(1'b1, 4 * n);
  endtask

  task automatic expect_char(string req, int idx, logic [7:0] d, logic p, logic f, logic b);
    chk(req, {21'd0, cap[idx]}, {21'd0, d, p, f, b});
  endtask

  task automatic t_reset;
    chk("R1 valid", rx_valid, 0);
    chk("R1 flags", {rx_perr, rx_ferr, rx_brk}, 0);
    chk("R1 data", rx_data, 0);
  endtask

  task automatic t_async;
    int n0 = ncap;
    cfg_sync = 0; cfg_par_en = 0;
    cfg_os = 2'b01; send_frame(8'hA5, 0, 0, 1, 16);
    cfg_os = 2'b00; send_frame(8'h3C, 0, 0, 1, 8);
    cfg_os = 2'b10; send_frame(8'h81, 0, 0, 1, 32);
    cfg_os = 2'b11; send_frame(8'h5A, 0, 0, 1, 16);
    send_bit(1'b0, 5); send_bit(1'b1, 40);
    chk("R2 count", ncap - n0, 4);
    expect_char("R2 16x", n0, 8'hA5, 0, 0, 0);
    expect_char("R2 8x", n0 + 1, 8'h3C, 0, 0, 0);
    expect_char("R2 32x", n0 + 2, 8'h81, 0, 0, 0);
    expect_char("R5 no parity bit", n0 + 3, 8'h5A, 0, 0, 0);
  endtask

  task automatic t_sync_parity;
    int n0 = ncap;
    cfg_sync = 1; cfg_par_en = 1;
    for (int m = 0; m < 4; m++) begin
      cfg_par_mode = m[1:0];
      send_frame(8'h6B, 1, par_of(8'h6B, m[1:0]), 1, 1);
      send_frame(8'h6B, 1, ~par_of(8'h6B, m[1:0]), 1, 1);
    end
    chk("R3 count", ncap - n0, 8);
    for (int m = 0; m < 4; m++) begin
      expect_char("R4 good parity", n0 + 2 * m, 8'h6B, 0, 0, 0);
      expect_char("R4 bad parity", n0 + 2 * m + 1, 8'h6B, 1, 0, 0);
    end
    n0 = ncap;
    cfg_par_mode = 2'b00;
    send_frame(8'h07, 1, par_of(8'h07, 2'b00), 1, 1);
    cfg_par_mode = 2'b10;
    send_frame(8'h07, 1, par_of(8'h07, 2'b00), 1, 1);
    expect_char("R5 mode change before", n0, 8'h07, 0, 0, 0);
    expect_char("R5 mode change after", n0 + 1, 8'h07, 1, 0, 0);
    cfg_par_en = 0;
  endtask

  task automatic t_framing;
    int n0 = ncap;
    cfg_sync = 1; cfg_zstop = 0;
    send_frame(8'h40, 0, 0, 0, 1);
    send_frame(8'h00, 0, 0, 0, 1);
    send_frame(8'h00, 0, 0, 1, 1);
    chk("R6 count", ncap - n0, 3);
    expect_char("R6 framing", n0, 8'h40, 0, 1, 0);
    expect_char("R7 break", n0 + 1, 8'h00, 0, 1, 1);
    expect_char("R6 zero with stop", n0 + 2, 8'h00, 0, 0, 0);
  endtask

  task automatic t_zero_stop;
    int n0 = ncap;
    cfg_sync = 1; cfg_zstop = 1;
    send_bit(1'b0, 1);
    for (int i = 0; i < 8; i++) send_bit(i[0] ? 1'b0 : 1'b1, 1);
    send_bit(1'b0, 1);
    for (int i = 0; i < 8; i++) send_bit(8'h12 >> i, 1);
    send_bit(1'b1, 5);
    send_bit(1'b0, 1);
    for (int i = 0; i < 8; i++) send_bit(1'b0, 1);
    send_bit(1'b0, 1);
    for (int i = 0; i < 8; i++) send_bit(1'b0, 1);
    send_bit(1'b0, 1);
    for (int i = 0; i < 8; i++) send_bit(1'b1, 1);
    send_bit(1'b1, 5);
    chk("R8 count", ncap - n0, 5);
    expect_char("R8 missing stop", n0, 8'h55, 0, 1, 0);
    expect_char("R8 resync char", n0 + 1, 8'h12, 0, 0, 0);
    expect_char("R9 first zero", n0 + 2, 8'h00, 0, 1, 0);
    expect_char("R9 second zero", n0 + 3, 8'h00, 0, 1, 1);
    expect_char("R8 after chain", n0 + 4, 8'hFF, 0, 0, 0);
  endtask

  task automatic t_zstop_async;
    int n0 = ncap;
    cfg_sync = 0; cfg_zstop = 1; cfg_os = 2'b01;
    send_frame(8'h00, 0, 0, 0, 16);
    send_bit(1'b1, 40);
    chk("R10 count", ncap - n0, 1);
    expect_char("R10 break normal rules", n0, 8'h00, 0, 1, 1);
    cfg_zstop = 0;
  endtask

  task automatic t_gate;
    int n0 = ncap;
    cfg_sync = 1; cfg_rx_gate = 1; tx_busy = 1;
    send_frame(8'hC3, 0, 0, 1, 1);
    chk("R11 ignored", ncap - n0, 0);
    tx_busy = 0;
    send_bit(1'b0, 1);
    for (int i = 0; i < 4; i++) send_bit(1'b1, 1);
    tx_busy = 1;
    for (int i = 0; i < 4; i++) send_bit(1'b1, 1);
    send_bit(1'b1, 3);
    tx_busy = 0;
    send_bit(1'b1, 12);
    chk("R11 partial dropped", ncap - n0, 0);
    cfg_rx_gate = 0; tx_busy = 1;
    send_frame(8'h3E, 0, 0, 1, 1);
    chk("R11 gate off count", ncap - n0, 1);
    expect_char("R11 gate off", n0, 8'h3E, 0, 0, 0);
    tx_busy = 0;
  endtask

  task automatic t_pulse;
    int hi = 0;
    cfg_sync = 1;
    fork
      send_frame(8'h99, 0, 0, 1, 1);
      repeat (20) @(negedge clk) if (rx_valid) hi++;
    join
    chk("R12 pulse width", hi, 1);
    send_bit(1'b1, 5);
    chk("R12 data held", {rx_valid, rx_data}, {1'b0, 8'h99});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1;
    repeat (3) @(negedge clk);
    t_async;
    t_sync_parity;
    t_framing;
    t_zero_stop;
    t_zstop_async;
    t_gate;
    t_pulse;
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    #500000;
    if (!done) begin
      done = 1;
      n_run++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule